// File: doc/BRIEF.md
# Thread-Partitioned Micro-Op Queue

This block sits at the boundary between an in-order instruction front end and an out-of-order back end. It buffers decoded micro-ops for up to two hardware threads and hands them out in program order for each thread. One storage array of `DEPTH` entries is shared. In single-thread mode, thread 0 may fill all of it. In two-thread mode, it is split into two private halves of `DEPTH/2` entries: thread 0 owns the lower half and thread 1 owns the upper half.

Three producer sources write bundles: the decoder path, the micro-op cache path and the microcode sequencer path. Each source has its own bundle-size limit. A bundle is all-or-nothing. In two-thread mode, the decoder write slot alternates between the threads on successive cycles. The consumer picks a thread and pops up to six micro-ops per cycle. A threading-mode change is requested through a level input. It takes effect only once both threads have drained. Each thread can also be flushed on its own.

Top module: `smt_uop_queue`

## Requirements
- R1: Per thread, micro-ops leave in the order they were written. Read slot i (`rd_data[i*W +: W]`) carries the i-th oldest entry of thread `rd_tid`. `rd_vld[i]` is 1 exactly when that thread holds more than i entries.
- R2: Single-thread mode (`mode_smt`=0) is the reset mode.
  - Thread 0 may hold up to 144 (`DEPTH`) entries, and `full[0]` is 1 at 144.
  - Thread 1 has no capacity: its writes are never accepted, and `full[1]`=`empty[1]`=1.
- R3: In two-thread mode (`mode_smt`=1), each thread owns a private 72-entry partition. `full[t]` is 1 at 72 entries, independently of the other thread.
- R4: A bundle is written only if the target thread has room for all `wr_cnt` ops, and no partial bundle is ever stored. `wr_ready[t]` is 1 when no mode change is pending and thread t has at least `wr_cnt` free entries.
- R5: The source limits are checked against `wr_cnt`:
  - `wr_src`=0 (decoder) accepts at most 6 ops.
  - `wr_src`=1 (op cache) accepts at most 8 ops.
  - `wr_src`=2 (microcode) accepts at most 4 ops.
  - `wr_src`=3 is never accepted.
  - A bundle with `wr_cnt`=0 is never accepted.
- R6: `wr_turn` is 0 after reset and toggles on every clock. In two-thread mode, a decoder write is accepted only when `wr_tid`==`wr_turn`; the other sources are not restricted.
- R7: While `mode_req`!=`mode_smt`, no write is accepted.
  - The mode changes on the first clock edge at which both threads hold zero entries.
  - `mode_smt` shows the new mode from the next cycle on.
- R8: `flush[t]` empties thread t at the next edge and rejects a write to thread t in the same cycle. The other thread's contents are unaffected.
- R9: A read removes min(`rd_pop`, 6, entries held) micro-ops from thread `rd_tid`. Larger `rd_pop` values are clamped.
- R10: After reset, the block is in single-thread mode, both threads are empty, `wr_turn`=0 and no read slot is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 1 | Requested mode: 1 = two threads |
| mode_smt | output | 1 | Current mode: 1 = two threads |
| wr_turn | output | 1 | Thread owning the decoder write slot this cycle |
| wr_valid | input | 1 | Write bundle present |
| wr_tid | input | 1 | Target thread of the bundle |
| wr_src | input | 2 | Source: 0 decoder, 1 op cache, 2 microcode |
| wr_cnt | input | 4 | Number of ops in the bundle |
| wr_data | input | WR_MAX*W | Bundle ops, slot 0 oldest |
| wr_ready | output | 2 | Per thread: room for the bundle and no mode change pending |
| wr_accept | output | 1 | Bundle is written this cycle |
| rd_tid | input | 1 | Thread being read |
| rd_pop | input | 3 | Ops to remove this cycle |
| rd_data | output | RD_MAX*W | Oldest ops of the selected thread |
| rd_vld | output | RD_MAX | Per read slot valid |
| flush | input | 2 | Per-thread flush |
| full | output | 2 | Per-thread full |
| empty | output | 2 | Per-thread empty |

## Verification
Several properties are checked by the assertions on every cycle:
- No thread's count ever exceeds its partition size.
- The mode changes only after a cycle with both threads empty.
- A flush empties its thread and leaves the other thread's count alone.
- Accepted decoder writes in two-thread mode never serve the same thread twice in a row.

Other behaviours only show up in the bench scenarios, which compare every read slot with a reference queue per thread:
- The data order across wrap-around.
- The exact reject decisions for bundle size, source limit and room.
- The hold of a mode request while entries remain.
- The survival of the other thread's data across a flush.

// File: rtl/smt_uop_queue.sv
module smt_uop_queue #(
  parameter int W       = 16,
  parameter int DEPTH   = 144,
  parameter int WR_MAX  = 8,
  parameter int RD_MAX  = 6,
  parameter int DEC_MAX = 6,
  parameter int UC_MAX  = 8,
  parameter int MS_MAX  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_req,
  output logic                 mode_smt,
  output logic                 wr_turn,
  input  logic                 wr_valid,
  input  logic                 wr_tid,
  input  logic [1:0]           wr_src,
  input  logic [3:0]           wr_cnt,
  input  logic [WR_MAX*W-1:0]  wr_data,
  output logic [1:0]           wr_ready,
  output logic                 wr_accept,
  input  logic                 rd_tid,
  input  logic [2:0]           rd_pop,
  output logic [RD_MAX*W-1:0]  rd_data,
  output logic [RD_MAX-1:0]    rd_vld,
  input  logic [1:0]           flush,
  output logic [1:0]           full,
  output logic [1:0]           empty
);
  localparam int HALF = DEPTH / 2;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int AW   = $clog2(DEPTH);

  logic [W-1:0]    mem [DEPTH];
  logic [CW-1:0]   cnt [2];
  logic [CW-1:0]   head [2];
  logic [CW-1:0]   cap [2];
  logic [CW-1:0]   w_tail, r_head, r_cnt, r_cap, npop, r_next;
  logic [3:0]      lim;
  logic [2:0]      pop_c;
  logic            pend, turn_ok;

  function automatic logic [CW-1:0] wrapc(input logic [CW:0] v, input logic [CW-1:0] c);
    return CW'((v >= {1'b0, c}) ? v - {1'b0, c} : v);
  endfunction

  function automatic logic [AW-1:0] addr(input logic t, input logic [CW:0] pos, input logic [CW-1:0] c);
    logic [CW:0] p;
    p = (pos >= {1'b0, c}) ? pos - {1'b0, c} : pos;
    return AW'(p) + (t ? AW'(HALF) : AW'(0));
  endfunction

  assign cap[0] = mode_smt ? CW'(HALF) : CW'(DEPTH);
  assign cap[1] = mode_smt ? CW'(HALF) : '0;
  assign pend   = mode_req != mode_smt;

  always_comb begin
    case (wr_src)
      2'd0:    lim = 4'(DEC_MAX);
      2'd1:    lim = 4'(UC_MAX);
      2'd2:    lim = 4'(MS_MAX);
      default: lim = '0;
    endcase
    for (int t = 0; t < 2; t++) begin
      wr_ready[t] = !pend && ((cap[t] - cnt[t]) >= CW'(wr_cnt));
      full[t]     = cnt[t] == cap[t];
      empty[t]    = cnt[t] == '0;
    end
  end

  assign turn_ok   = !(mode_smt && wr_src == 2'd0) || (wr_tid == wr_turn);
  assign wr_accept = wr_valid && (wr_cnt != '0) && (wr_cnt <= lim) && wr_ready[wr_tid]
                     && turn_ok && !flush[wr_tid];
  assign w_tail    = wrapc({1'b0, head[wr_tid]} + {1'b0, cnt[wr_tid]}, cap[wr_tid]);

  assign r_head = head[rd_tid];
  assign r_cnt  = cnt[rd_tid];
  assign r_cap  = cap[rd_tid];
  assign pop_c  = (rd_pop > 3'(RD_MAX)) ? 3'(RD_MAX) : rd_pop;
  assign npop   = (CW'(pop_c) > r_cnt) ? r_cnt : CW'(pop_c);
  assign r_next = wrapc({1'b0, r_head} + {1'b0, npop}, r_cap);

  always_comb begin
    for (int i = 0; i < RD_MAX; i++) begin
      rd_vld[i]          = CW'(i) < r_cnt;
      rd_data[i*W +: W]  = mem[addr(rd_tid, {1'b0, r_head} + (CW+1)'(i), r_cap)];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < WR_MAX; i++)
      if (wr_accept && (4'(i) < wr_cnt))
        mem[addr(wr_tid, {1'b0, w_tail} + (CW+1)'(i), cap[wr_tid])] <= wr_data[i*W +: W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_smt <= 1'b0;
      wr_turn  <= 1'b0;
      for (int t = 0; t < 2; t++) begin
        cnt[t]  <= '0;
        head[t] <= '0;
      end
    end else begin
      wr_turn <= !wr_turn;
      for (int t = 0; t < 2; t++) begin
        if (flush[t]) begin
          cnt[t]  <= '0;
          head[t] <= '0;
        end else begin
          cnt[t] <= cnt[t] + ((wr_accept && wr_tid == 1'(t)) ? CW'(wr_cnt) : '0)
                           - ((rd_tid == 1'(t)) ? npop : '0);
          if (rd_tid == 1'(t)) head[t] <= r_next;
        end
      end
      if (pend && cnt[0] == '0 && cnt[1] == '0) begin
        mode_smt <= mode_req;
        head[0]  <= '0;
        head[1]  <= '0;
      end
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[0] <= cap[0]) && (cnt[1] <= cap[1]));

  assert_mode_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_smt != $past(mode_smt)) |-> ($past(cnt[0]) == '0 && $past(cnt[1]) == '0));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush[0] |=> empty[0]);

  assert_flush1_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush[1] |=> empty[1]);

  assert_flush_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush[0] && !flush[1] && !(wr_accept && wr_tid) && !(rd_tid && rd_pop != '0))
      |=> (cnt[1] == $past(cnt[1])));

  assert_dec_alternate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_smt && wr_accept && wr_src == 2'd0)
      |=> !(mode_smt && wr_accept && wr_src == 2'd0 && wr_tid == $past(wr_tid)));
endmodule

// File: tb/sim_smt_uop_queue.sv
`timescale 1ns/1ps
module sim_smt_uop_queue;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_req = 1'b0, mode_smt, wr_turn;
  logic wr_valid = 1'b0, wr_tid = 1'b0;
  logic [1:0] wr_src = '0;
  logic [3:0] wr_cnt = '0;
  logic [127:0] wr_data = '0;
  logic [1:0] wr_ready, flush = '0, full, empty;
  logic wr_accept, rd_tid = 1'b0;
  logic [2:0] rd_pop = '0;
  logic [95:0] rd_data;
  logic [5:0] rd_vld;

  int tests = 0, fails = 0, seq = 1;
  bit m_smt = 0, tb_turn = 0, mreq = 0;
  logic [15:0] q0[$], q1[$];

  always #2.5 clk = ~clk;

  smt_uop_queue u0 (.clk, .rst_n, .mode_req, .mode_smt, .wr_turn, .wr_valid, .wr_tid,
    .wr_src, .wr_cnt, .wr_data, .wr_ready, .wr_accept, .rd_tid, .rd_pop, .rd_data,
    .rd_vld, .flush, .full, .empty);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit wv, input bit tid, input bit [1:0] src, input int n,
                     input int pop, input bit rtid, input bit [1:0] fl, input string tag);
    int lim, c[2], sz[2], np, vcnt;
    bit pend, acc, xr;
    @(negedge clk);
    wr_valid = wv; wr_tid = tid; wr_src = src; wr_cnt = 4'(n);
    for (int i = 0; i < 8; i++) wr_data[i*16 +: 16] = 16'(seq + i);
    rd_tid = rtid; rd_pop = 3'(pop); flush = fl; mode_req = mreq;
    #1;
    c[0] = m_smt ? 72 : 144; c[1] = m_smt ? 72 : 0;
    sz[0] = q0.size(); sz[1] = q1.size();
    pend = mreq != m_smt;
    lim = (src == 0) ? 6 : (src == 1) ? 8 : (src == 2) ? 4 : 0;
    acc = wv && n > 0 && n <= lim && (c[tid] - sz[tid] >= n) && !pend
          && !(m_smt && src == 0 && tid != tb_turn) && !fl[tid];
    chk(wr_accept == acc, tag, wr_accept, acc);
    for (int t = 0; t < 2; t++) begin
      xr = !pend && (c[t] - sz[t] >= (wv ? n : 0));
      if (wv) chk(wr_ready[t] == xr, "R4", wr_ready[t], xr);
      chk(empty[t] == (sz[t] == 0), m_smt ? "R3" : "R2", empty[t], sz[t] == 0);
      chk(full[t] == (sz[t] == c[t]), m_smt ? "R3" : "R2", full[t], sz[t] == c[t]);
    end
    chk(wr_turn == tb_turn, "R6", wr_turn, tb_turn);
    chk(mode_smt == m_smt, "R7", mode_smt, m_smt);
    vcnt = 0;
    for (int i = 0; i < 6; i++) begin
      xr = i < sz[rtid];
      vcnt += int'(rd_vld[i]);
      chk(rd_vld[i] == xr, "R1", rd_vld[i], xr);
      if (xr) chk(rd_data[i*16 +: 16] == (rtid ? q1[i] : q0[i]), "R1",
                  rd_data[i*16 +: 16], rtid ? q1[i] : q0[i]);
    end
    chk(vcnt == ((sz[rtid] < 6) ? sz[rtid] : 6), "R9", vcnt, (sz[rtid] < 6) ? sz[rtid] : 6);
    @(posedge clk);
    np = (pop > 6) ? 6 : pop;
    if (np > sz[rtid]) np = sz[rtid];
    for (int t = 0; t < 2; t++) begin
      if (fl[t]) begin
        if (t == 0) q0.delete(); else q1.delete();
      end else begin
        if (rtid == 1'(t)) for (int k = 0; k < np; k++) if (t == 0) void'(q0.pop_front()); else void'(q1.pop_front());
        if (acc && tid == 1'(t)) for (int k = 0; k < n; k++) if (t == 0) q0.push_back(16'(seq + k)); else q1.push_back(16'(seq + k));
      end
    end
    if (pend && sz[0] == 0 && sz[1] == 0) m_smt = mreq;
    tb_turn = !tb_turn;
    seq += 8;
  endtask

  localparam bit [6:0] TBL [9] = '{
    {1'b0, 2'd0, 4'd6}, {1'b0, 2'd0, 4'd7}, {1'b0, 2'd1, 4'd8},
    {1'b0, 2'd2, 4'd4}, {1'b0, 2'd2, 4'd5}, {1'b1, 2'd1, 4'd2},
    {1'b0, 2'd3, 4'd1}, {1'b0, 2'd0, 4'd0}, {1'b0, 2'd1, 4'd3}};

  initial begin
    #1000000;
    fails++; tests++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    chk(mode_smt == 1'b0, "R10", mode_smt, 0);
    chk(empty == 2'b11, "R10", empty, 3);
    chk(wr_turn == 1'b0, "R10", wr_turn, 0);
    chk(rd_vld == '0, "R10", rd_vld, 0);
    @(posedge clk); tb_turn = 1;

    for (int k = 0; k < 9; k++)
      cyc(1, TBL[k][6], TBL[k][5:4], int'(TBL[k][3:0]), 0, 0, 0, "R5");
    cyc(0, 0, 0, 0, 2, 0, 0, "R9");
    cyc(0, 0, 0, 0, 7, 0, 0, "R9");
    while (q0.size() > 0) cyc(0, 0, 0, 0, 6, 0, 0, "R1");

    for (int k = 0; k < 17; k++) cyc(1, 0, 1, 8, 0, 0, 0, "R2");
    cyc(1, 0, 2, 4, 0, 0, 0, "R2");
    cyc(1, 0, 1, 8, 0, 0, 0, "R4");
    cyc(1, 0, 2, 4, 0, 0, 0, "R2");
    chk(q0.size() == 144, "R2", q0.size(), 144);
    cyc(1, 0, 2, 1, 0, 0, 0, "R2");

    mreq = 1;
    while (q0.size() > 0) cyc(1, 0, 2, 1, 6, 0, 0, "R7");
    cyc(1, 0, 2, 1, 0, 0, 0, "R7");
    chk(m_smt == 1'b1, "R7", m_smt, 1);

    for (int k = 0; k < 8; k++) cyc(1, tb_turn, 0, 6, 0, 0, 0, "R6");
    cyc(1, !tb_turn, 0, 6, 0, 0, 0, "R6");
    cyc(1, !tb_turn, 0, 2, 0, 0, 0, "R6");
    for (int k = 0; k < 12; k++) cyc(1, 1'(k), 1, 8, 0, 1, 0, "R3");
    cyc(1, 0, 1, 1, 0, 0, 0, "R3");
    cyc(1, 1, 2, 1, 0, 1, 0, "R3");

    cyc(0, 0, 0, 0, 6, 1, 0, "R1");
    cyc(1, 1, 2, 4, 0, 1, 2'b01, "R8");
    cyc(1, 0, 1, 3, 0, 0, 2'b01, "R8");
    cyc(0, 0, 0, 0, 0, 1, 0, "R8");
    chk(q1.size() == 70 && empty[0] == 1'b1, "R8", q1.size(), 70);

    mreq = 0;
    while (q1.size() > 0) cyc(1, 1, 2, 2, 5, 1, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, 0, "R7");
    cyc(1, 0, 1, 8, 0, 0, 0, "R2");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule